// File: doc/BRIEF.md
# Packet Link Adaptor Register Block

This block is the software-visible register file of a full-duplex, point-to-point packet adaptor. It decodes a word-addressed space of eight offsets. That space holds a buffer base address and a 20-bit line count for each direction, and a data window onto each direction's FIFO. It also holds a shared offset that returns status on reads and takes commands on writes, and a constant identifier. The transmit and receive engines sit outside the block. They see it as command pulses, a loopback level and buffer registers, and they return their busy, done, error and FIFO-level flags.

A host stores the buffer registers, issues a reset, then a start, and then waits on the interrupt or polls the status word. Command bits act only when written as 1. A reset and a start written together are split in time, so the engine is cleared before it is launched. A parity-error flag, kept locally, is set on a bad bus access or a bad DMA transfer and is cleared by any control write.

Top module: `lnk_csr_top`

## Requirements
- R1: A write to offset 0 or 4 stores the transmit or receive buffer address with bits [1:0] forced to zero. A write to offset 1 or 5 stores wdata[19:0] as that direction's line count. Reads of these offsets return the stored value, with the count zero-extended. Each value is visible on the output ports and on the read bus from the cycle after the write. After reset all four registers are zero.
- R2: Offset 7 always reads 0x00000006, and writes to it change no output.
- R3: A read of offset 3 returns, in the same cycle: bit 23 tx busy, bit 22 tx done, bit 21 tx underrun, bits 20:13 tx level, bit 12 rx busy, bit 11 rx done, bit 10 rx overrun, bits 9:2 rx level, bit 1 rx CRC error, bit 0 the local parity-error flag. Bits 31:24 are zero.
- R4: A write to offset 3 with bit 0 (tx reset) or bit 2 (rx reset) set gives a one-cycle pulse on that reset output in the next cycle. A 0 in a command bit produces no pulse.
- R5: Bit 1 (tx start) or bit 3 (rx start) of a control write gives a one-cycle start pulse in the next cycle. If the same write also sets that direction's reset bit, the reset pulse comes first and the start pulse follows one cycle later. A reset for that direction written in the intervening cycle cancels the delayed start.
- R6: Bit 4 of every control write is held on the loopback output from the next cycle until the next control write. Offset 3 never reads back the control value.
- R7: A read of offset 2 or 6 pops the transmit or receive FIFO in the same cycle and returns that FIFO's head word. A write to those offsets pushes the bus data. No other access raises a push or pop strobe.
- R8: The parity-error flag is set in the next cycle when the bus parity error is high during a read or write, or when the DMA parity error is high. It is cleared by any control write. If a set and a clear fall in the same cycle, the set wins. A bus parity error with no access is ignored.
- R9: The interrupt is high while any of tx done, tx underrun, rx done, rx overrun or the parity-error flag is high.
- R10: After reset no command pulse is active, loopback is 0 and the parity-error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 32 | Write data, also the FIFO push data |
| bus_perr_i | input | 1 | Parity error on the current access |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| dma_perr_i | input | 1 | Parity error seen on a DMA transfer |
| tx_addr_o | output | 32 | Transmit buffer base address |
| tx_len_o | output | 20 | Transmit line count |
| rx_addr_o | output | 32 | Receive buffer base address |
| rx_len_o | output | 20 | Receive line limit |
| tx_push_o | output | 1 | Push bus data into the transmit FIFO |
| tx_pop_o | output | 1 | Pop the transmit FIFO |
| tx_head_i | input | 32 | Transmit FIFO head word |
| rx_push_o | output | 1 | Push bus data into the receive FIFO |
| rx_pop_o | output | 1 | Pop the receive FIFO |
| rx_head_i | input | 32 | Receive FIFO head word |
| tx_rst_o | output | 1 | Transmit reset pulse |
| tx_go_o | output | 1 | Transmit start pulse |
| rx_rst_o | output | 1 | Receive reset pulse |
| rx_go_o | output | 1 | Receive start pulse |
| loop_o | output | 1 | Loopback level |
| tx_busy_i | input | 1 | Transmitter busy with a packet |
| tx_done_i | input | 1 | Transmit packet completed |
| tx_underrun_i | input | 1 | Transmit FIFO underrun |
| tx_level_i | input | 8 | Transmit FIFO word count |
| rx_busy_i | input | 1 | Receiver armed or receiving |
| rx_done_i | input | 1 | Receive packet completed |
| rx_overrun_i | input | 1 | Receive FIFO overrun |
| rx_level_i | input | 8 | Receive FIFO word count |
| rx_crc_err_i | input | 1 | Received CRC mismatch |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle. A control write that clears the parity-error flag can coincide with a fresh parity error. A reset and a start for one direction can arrive in a single control word. The bench provokes the first with directed control writes that carry the bus parity error or the DMA parity error. It provokes the second with words that set both bits, followed in the next cycle by a word that carries another reset or none. Long random runs of mixed accesses repeat both. A behavioural model predicts every output each cycle. It expects the flag to stay set and the start pulse to trail the reset by exactly one cycle, or to be dropped.

// File: rtl/lnk_csr_pkg.sv
package lnk_csr_pkg;

    typedef enum logic [2:0] {
        OFF_TX_ADDR  = 3'd0,
        OFF_TX_LEN   = 3'd1,
        OFF_TX_DATA  = 3'd2,
        OFF_STAT_CTL = 3'd3,
        OFF_RX_ADDR  = 3'd4,
        OFF_RX_LEN   = 3'd5,
        OFF_RX_DATA  = 3'd6,
        OFF_IDENT    = 3'd7
    } csr_off_e;

    // control word: per direction a reset bit at 2*dir and a start bit at 2*dir+1
    localparam int CTL_LOOP_BIT = 4;
    localparam int CHAN_STRIDE  = 4;   // offset distance between tx and rx groups

    typedef struct packed {
        logic rst;
        logic go;
        logic go_pend;
    } cmd_state_t;

    typedef struct packed {
        logic loop;
        logic bpe;
    } ctl_state_t;

endpackage

// File: rtl/lnk_csr_bufreg.sv
module lnk_csr_bufreg #(
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 20,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              len_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o
);

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } buf_state_t;

    buf_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (addr_we) begin
            state_d.addr = {wdata[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
        if (len_we) begin
            state_d.len = wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign addr_o = state_q.addr;
    assign len_o  = state_q.len;

    p_addr_aligned_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> (addr_o[DATA_W-1:ALIGN_BITS] == $past(wdata[DATA_W-1:ALIGN_BITS]))
                    && (addr_o[ALIGN_BITS-1:0] == '0));

    p_len_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        len_we |=> len_o == $past(wdata[LEN_W-1:0]));

    p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !len_we) |=> ($stable(addr_o) && $stable(len_o)));

endmodule

// File: rtl/lnk_csr_cmd.sv
module lnk_csr_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic rst_bit,
    input  logic go_bit,
    output logic rst_o,
    output logic go_o
);
    import lnk_csr_pkg::*;

    cmd_state_t state_d, state_q;
    logic       rst_req, go_req;

    always_comb begin
        rst_req         = ctl_we && rst_bit;
        go_req          = ctl_we && go_bit;
        state_d.rst     = rst_req;
        state_d.go_pend = rst_req && go_req;
        state_d.go      = !rst_req && (go_req || state_q.go_pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rst_o = state_q.rst;
    assign go_o  = state_q.go;

    p_rst_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && rst_bit) |=> rst_o);

    p_rst_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> $past(ctl_we && rst_bit));

    p_reset_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && rst_bit && go_bit) |=> (rst_o && !go_o));

    p_start_trails_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_we && rst_bit && go_bit) && !(ctl_we && rst_bit)) |=> go_o);

    p_go_never_with_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_o && rst_o));

endmodule

// File: rtl/lnk_csr_ctl.sv
module lnk_csr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic loop_bit,
    input  logic perr_set,
    output logic loop_o,
    output logic bpe_o
);
    import lnk_csr_pkg::*;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        if (ctl_we) begin
            state_d.loop = loop_bit;
        end
        // a new error outranks the clear carried by a control write
        state_d.bpe  = perr_set || (state_q.bpe && !ctl_we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign loop_o = state_q.loop;
    assign bpe_o  = state_q.bpe;

    p_bpe_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        perr_set |=> bpe_o);

    p_bpe_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !perr_set) |=> !bpe_o);

    p_bpe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bpe_o && !ctl_we) |=> bpe_o);

    p_loop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(loop_o));

endmodule

// File: rtl/lnk_csr_top.sv
module lnk_csr_top #(
    parameter int              DATA_W   = 32,
    parameter int              LEN_W    = 20,
    parameter int              CNT_W    = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0000_0006
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_perr_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              dma_perr_i,
    output logic [DATA_W-1:0] tx_addr_o,
    output logic [LEN_W-1:0]  tx_len_o,
    output logic [DATA_W-1:0] rx_addr_o,
    output logic [LEN_W-1:0]  rx_len_o,
    output logic              tx_push_o,
    output logic              tx_pop_o,
    input  logic [DATA_W-1:0] tx_head_i,
    output logic              rx_push_o,
    output logic              rx_pop_o,
    input  logic [DATA_W-1:0] rx_head_i,
    output logic              tx_rst_o,
    output logic              tx_go_o,
    output logic              rx_rst_o,
    output logic              rx_go_o,
    output logic              loop_o,
    input  logic              tx_busy_i,
    input  logic              tx_done_i,
    input  logic              tx_underrun_i,
    input  logic [CNT_W-1:0]  tx_level_i,
    input  logic              rx_busy_i,
    input  logic              rx_done_i,
    input  logic              rx_overrun_i,
    input  logic [CNT_W-1:0]  rx_level_i,
    input  logic              rx_crc_err_i,
    output logic              irq_o
);
    import lnk_csr_pkg::*;

    localparam int N_CHAN = 2;
    localparam int PAD_W  = DATA_W - 2 * CNT_W - 8;

    logic              ctl_we;
    logic              perr_set;
    logic              bpe;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] ch_addr [N_CHAN];
    logic [LEN_W-1:0]  ch_len  [N_CHAN];
    logic              ch_rst  [N_CHAN];
    logic              ch_go   [N_CHAN];
    logic              ch_push [N_CHAN];
    logic              ch_pop  [N_CHAN];
    logic [DATA_W-1:0] ch_head [N_CHAN];

    assign ctl_we     = bus_wr_i && (bus_addr_i == OFF_STAT_CTL);
    assign perr_set   = ((bus_wr_i || bus_rd_i) && bus_perr_i) || dma_perr_i;
    assign ch_head[0] = tx_head_i;
    assign ch_head[1] = rx_head_i;

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        localparam logic [2:0] BASE = 3'(g * CHAN_STRIDE);

        assign ch_push[g] = bus_wr_i && (bus_addr_i == BASE + 3'(OFF_TX_DATA));
        assign ch_pop[g]  = bus_rd_i && (bus_addr_i == BASE + 3'(OFF_TX_DATA));

        lnk_csr_bufreg #(
            .DATA_W     (DATA_W),
            .LEN_W      (LEN_W),
            .ALIGN_BITS (2)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr_we (bus_wr_i && (bus_addr_i == BASE + 3'(OFF_TX_ADDR))),
            .len_we  (bus_wr_i && (bus_addr_i == BASE + 3'(OFF_TX_LEN))),
            .wdata   (bus_wdata_i),
            .addr_o  (ch_addr[g]),
            .len_o   (ch_len[g])
        );

        lnk_csr_cmd u_cmd (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (ctl_we),
            .rst_bit (bus_wdata_i[2*g]),
            .go_bit  (bus_wdata_i[2*g+1]),
            .rst_o   (ch_rst[g]),
            .go_o    (ch_go[g])
        );
    end

    lnk_csr_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .loop_bit (bus_wdata_i[CTL_LOOP_BIT]),
        .perr_set (perr_set),
        .loop_o   (loop_o),
        .bpe_o    (bpe)
    );

    assign status_w = {{PAD_W{1'b0}},
                       tx_busy_i, tx_done_i, tx_underrun_i, tx_level_i,
                       rx_busy_i, rx_done_i, rx_overrun_i, rx_level_i,
                       rx_crc_err_i, bpe};

    always_comb begin
        unique case (csr_off_e'(bus_addr_i))
            OFF_TX_ADDR:  bus_rdata_o = ch_addr[0];
            OFF_TX_LEN:   bus_rdata_o = DATA_W'(ch_len[0]);
            OFF_TX_DATA:  bus_rdata_o = ch_head[0];
            OFF_STAT_CTL: bus_rdata_o = status_w;
            OFF_RX_ADDR:  bus_rdata_o = ch_addr[1];
            OFF_RX_LEN:   bus_rdata_o = DATA_W'(ch_len[1]);
            OFF_RX_DATA:  bus_rdata_o = ch_head[1];
            default:      bus_rdata_o = ID_VALUE;
        endcase
    end

    assign tx_addr_o = ch_addr[0];
    assign tx_len_o  = ch_len[0];
    assign rx_addr_o = ch_addr[1];
    assign rx_len_o  = ch_len[1];
    assign tx_push_o = ch_push[0];
    assign tx_pop_o  = ch_pop[0];
    assign rx_push_o = ch_push[1];
    assign rx_pop_o  = ch_pop[1];
    assign tx_rst_o  = ch_rst[0];
    assign tx_go_o   = ch_go[0];
    assign rx_rst_o  = ch_rst[1];
    assign rx_go_o   = ch_go[1];

    assign irq_o = tx_done_i || tx_underrun_i || rx_done_i || rx_overrun_i || bpe;

    p_irq_on_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        perr_set |=> irq_o);

    p_ident_write_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFF_IDENT) |=>
            ($stable(tx_addr_o) && $stable(rx_addr_o) && $stable(tx_len_o) && $stable(rx_len_o)));

    p_status_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFF_STAT_CTL) |-> bus_rdata_o[DATA_W-1:DATA_W-PAD_W] == '0);

endmodule

// File: tb/lnk_csr_top_tb.sv
`timescale 1ns/1ps
module lnk_csr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0, bus_perr = 0, dma_perr = 0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, tx_head = '0, rx_head = '0;
    logic        tx_busy = 0, tx_done = 0, tx_under = 0, rx_busy = 0, rx_done = 0, rx_over = 0, rx_crc = 0;
    logic [7:0]  tx_lvl = '0, rx_lvl = '0;

    logic [31:0] rdata, tx_addr, rx_addr;
    logic [19:0] tx_len, rx_len;
    logic        tx_push, tx_pop, rx_push, rx_pop, tx_rst, tx_go, rx_rst, rx_go, loop_en, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    lnk_csr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_perr_i(bus_perr), .bus_rdata_o(rdata), .dma_perr_i(dma_perr),
        .tx_addr_o(tx_addr), .tx_len_o(tx_len), .rx_addr_o(rx_addr), .rx_len_o(rx_len),
        .tx_push_o(tx_push), .tx_pop_o(tx_pop), .tx_head_i(tx_head),
        .rx_push_o(rx_push), .rx_pop_o(rx_pop), .rx_head_i(rx_head),
        .tx_rst_o(tx_rst), .tx_go_o(tx_go), .rx_rst_o(rx_rst), .rx_go_o(rx_go), .loop_o(loop_en),
        .tx_busy_i(tx_busy), .tx_done_i(tx_done), .tx_underrun_i(tx_under), .tx_level_i(tx_lvl),
        .rx_busy_i(rx_busy), .rx_done_i(rx_done), .rx_overrun_i(rx_over), .rx_level_i(rx_lvl),
        .rx_crc_err_i(rx_crc), .irq_o(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_addr [2];
    logic [19:0] m_len  [2];
    logic        m_rst [2];
    logic        m_go  [2];
    int          m_go_due [2];   // cycle number at which a delayed start is owed, -1 if none
    logic        m_loop, m_bpe;
    int          cyc_n = 0;

    always @(posedge clk) begin
        cyc_n = cyc_n + 1;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_addr[c] = '0; m_len[c] = '0; m_rst[c] = 0; m_go[c] = 0; m_go_due[c] = -1;
            end
            m_loop = 0; m_bpe = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit rs, gs;
                rs = bus_wr && bus_addr == 3 && bus_wdata[2*c];
                gs = bus_wr && bus_addr == 3 && bus_wdata[2*c+1];
                if (bus_wr && bus_addr == 3'(4*c))     m_addr[c] = bus_wdata & 32'hFFFF_FFFC;
                if (bus_wr && bus_addr == 3'(4*c + 1)) m_len[c]  = bus_wdata[19:0];
                m_rst[c] = rs;
                if (rs) begin
                    m_go[c]     = 0;
                    m_go_due[c] = gs ? cyc_n + 1 : -1;
                end else begin
                    m_go[c]     = gs || (m_go_due[c] == cyc_n);
                    m_go_due[c] = -1;
                end
            end
            if (bus_wr && bus_addr == 3) m_loop = bus_wdata[4];
            if (((bus_wr || bus_rd) && bus_perr) || dma_perr) m_bpe = 1;
            else if (bus_wr && bus_addr == 3)                 m_bpe = 0;
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (bus_addr)
            3'd0: return m_addr[0];
            3'd1: return {12'h0, m_len[0]};
            3'd2: return tx_head;
            3'd3: return {8'h00, tx_busy, tx_done, tx_under, tx_lvl,
                          rx_busy, rx_done, rx_over, rx_lvl, rx_crc, m_bpe};
            3'd4: return m_addr[1];
            3'd5: return {12'h0, m_len[1]};
            3'd6: return rx_head;
            default: return 32'h0000_0006;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc_n, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R1", "tx_addr", tx_addr, m_addr[0]);
            check("R1", "tx_len",  {12'h0, tx_len}, {12'h0, m_len[0]});
            check("R1", "rx_addr", rx_addr, m_addr[1]);
            check("R1", "rx_len",  {12'h0, rx_len}, {12'h0, m_len[1]});
            if (bus_addr == 3'd7)      check("R2", "ident",  rdata, exp_rdata());
            else if (bus_addr == 3'd3) check("R3", "status", rdata, exp_rdata());
            else                       check("R1", "rdata",  rdata, exp_rdata());
            check("R4", "tx_rst", 32'(tx_rst), 32'(m_rst[0]));
            check("R4", "rx_rst", 32'(rx_rst), 32'(m_rst[1]));
            check("R5", "tx_go",  32'(tx_go),  32'(m_go[0]));
            check("R5", "rx_go",  32'(rx_go),  32'(m_go[1]));
            check("R6", "loop",   32'(loop_en), 32'(m_loop));
            check("R7", "strobes", {28'h0, tx_push, tx_pop, rx_push, rx_pop},
                  {28'h0, bus_wr && bus_addr == 2, bus_rd && bus_addr == 2,
                          bus_wr && bus_addr == 6, bus_rd && bus_addr == 6});
            check("R9", "irq", 32'(irq), 32'(tx_done || tx_under || rx_done || rx_over || m_bpe));
        end else begin
            check("R10", "reset outputs",
                  {24'h0, tx_rst, tx_go, rx_rst, rx_go, loop_en, irq, 2'b00}, 32'h0);
            check("R10", "reset regs", tx_addr | rx_addr | {12'h0, tx_len | rx_len}, 32'h0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d,
                       input logic pe, input logic de, input logic rnd_stat);
        @(posedge clk);
        #1;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; bus_perr = pe; dma_perr = de;
        tx_head = $urandom; rx_head = $urandom;
        if (rnd_stat) begin
            {tx_busy, tx_done, tx_under, rx_busy, rx_done, rx_over, rx_crc} = 7'($urandom);
            tx_lvl = 8'($urandom); rx_lvl = 8'($urandom);
        end else begin
            {tx_busy, tx_done, tx_under, rx_busy, rx_done, rx_over, rx_crc} = '0;
        end
    endtask

    task automatic idle(); cyc(0, 0, 3'd0, 32'h0, 0, 0, 0); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        // R1: alignment, length truncation, readback
        cyc(1, 0, 3'd0, 32'h1234_5677, 0, 0, 0);
        cyc(1, 0, 3'd1, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 0, 3'd4, 32'hDEAD_BEEF, 0, 0, 0);
        cyc(1, 0, 3'd5, 32'h000A_BCDE, 0, 0, 0);
        for (int a = 0; a < 8; a++) cyc(0, 1, 3'(a), 32'h0, 0, 0, 1);
        // R2: writes to identifier are inert
        cyc(1, 0, 3'd7, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(0, 1, 3'd7, 32'h0, 0, 0, 0);
        // R4/R5: zero write, single commands, combined reset+start, cancel
        cyc(1, 0, 3'd3, 32'h0, 0, 0, 0);
        idle();
        cyc(1, 0, 3'd3, 32'h0000_0002, 0, 0, 0);
        idle();
        cyc(1, 0, 3'd3, 32'h0000_000F, 0, 0, 0);
        idle(); idle();
        cyc(1, 0, 3'd3, 32'h0000_0003, 0, 0, 0);
        cyc(1, 0, 3'd3, 32'h0000_0001, 0, 0, 0);
        idle(); idle();
        // R6: loop level, status read not control
        cyc(1, 0, 3'd3, 32'h0000_0010, 0, 0, 0);
        cyc(0, 1, 3'd3, 32'h0, 0, 0, 0);
        idle();
        // R7: FIFO window
        cyc(1, 0, 3'd2, 32'hA5A5_0001, 0, 0, 0);
        cyc(0, 1, 3'd2, 32'h0, 0, 0, 0);
        cyc(1, 0, 3'd6, 32'hA5A5_0002, 0, 0, 0);
        cyc(0, 1, 3'd6, 32'h0, 0, 0, 0);
        // R8: parity error without access is ignored, then set, then clear vs. set
        cyc(0, 0, 3'd0, 32'h0, 1, 0, 0);
        idle();
        cyc(0, 1, 3'd1, 32'h0, 1, 0, 0);
        cyc(0, 1, 3'd3, 32'h0, 0, 0, 0);
        cyc(1, 0, 3'd3, 32'h0, 1, 0, 0);
        cyc(0, 1, 3'd3, 32'h0, 0, 0, 0);
        cyc(1, 0, 3'd3, 32'h0, 0, 1, 0);
        idle();
        cyc(1, 0, 3'd3, 32'h0, 0, 0, 0);
        cyc(0, 1, 3'd3, 32'h0, 0, 0, 0);
        // mixed random traffic
        for (int i = 0; i < 6000; i++) begin
            int      kind;
            logic [31:0] d;
            kind = $urandom_range(0, 9);
            d    = $urandom;
            if (kind < 4)      cyc(1, 0, 3'($urandom), d, ($urandom_range(0, 15) == 0), ($urandom_range(0, 31) == 0), 1);
            else if (kind < 6) cyc(1, 0, 3'd3, d & 32'h1F, ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0), 1);
            else if (kind < 9) cyc(0, 1, 3'($urandom), 32'h0, ($urandom_range(0, 15) == 0), 0, 1);
            else               cyc(0, 0, 3'($urandom), d, $urandom_range(0, 1) == 1, 0, 1);
        end
        idle(); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule